// File: doc/BRIEF.md
# SD Host Control-2 Register

This block holds the second host-control word of an SD/SDIO host controller. Software writes it through a plain 16-bit write port and reads the live contents back at any time. The word selects the I/O signaling level (3.3 V or 1.8 V), the UHS-I bus speed mode and the output driver type. It also carries the asynchronous-interrupt enable, and it runs the handshake that starts and aborts an external sampling-clock tuning engine and records whether tuning passed.

A preset-enable bit chooses where the clock divider, the clock-generator select and the driver type come from. When it is clear, they come from user values: the driver field of this word, plus a divider and a generator select supplied from elsewhere in the controller. When it is set, they come from a bank of preset entries, and the entry used is the one indexed by the speed-mode code. The results are driven onto the effective-setting outputs, which feed the clock generator and the pad drivers.

Top module: `sdhc_ctrl2_reg`

## Requirements
- R1: After reset the read word is 0x0000, every pulse output is low, the effective driver type is 0, and the effective divider and generator select equal the user inputs.
- R2: Each accepted write stores bit 15 (preset enable), bit 14 (async-interrupt enable), bits 5:4 (driver type), bit 3 (1.8 V enable) and bits 2:0 (speed mode). These are visible on the read word at the same positions from the cycle after the write. Bits 13:8 always read zero.
- R3: A write with bit 6 = 1 while bit 6 is clear sets bit 6, raises `tune_start` for exactly one cycle and clears bit 7 (unless blocked per R7). A write with bit 6 = 1 while bit 6 is already set changes neither bit and gives no pulse.
- R4: `tune_done` while bit 6 is set clears bit 6 and loads bit 7 with `tune_pass`. `tune_done` while bit 6 is clear has no effect. A completion takes priority over any write in the same cycle.
- R5: A write with bit 6 = 0 while bit 6 is set clears bit 6 and raises `tune_abort` for exactly one cycle.
- R6: A write never sets bit 7. A write with bit 7 = 0 clears bit 7 and raises `tuner_rst` for one cycle.
- R7: While `resp_busy` or `rdata_busy` is high, no write changes bit 7 and `tuner_rst` stays low.
- R8: With preset enable set and speed code k in 0..N_PRESET-1, the effective divider, generator select and driver type come from preset entry k. In `preset_bank`, entry k occupies bits [k*(DIV_W+3) +: DIV_W+3]. Within an entry, the divider is the low DIV_W bits, the generator select is bit DIV_W and the driver type is bits DIV_W+2:DIV_W+1. With preset enable clear, the user values are used.
- R9: Speed codes 5 to 7 select no preset entry: the user divider, generator select and driver type stay in effect even with preset enable set.
- R10: While bit 3 is 0 (3.3 V signaling), the effective driver type is 0 (type B). Driver codes are 0 = B, 1 = A, 2 = C, 3 = D.
- R11: `uhs_active` is high only when bit 3 = 1, `ddr_mode` = 0 and the speed code is 0..4 (0 SDR12, 1 SDR25, 2 SDR50, 3 SDR104, 4 DDR50). `eff_uhs_mode` equals the code when active and 0 otherwise.
- R12: `volt_1v8` follows bit 3. `vsw_up` pulses for one cycle when bit 3 goes from 0 to 1, and `vsw_down` pulses for one cycle when it goes from 1 to 0.
- R13: `async_irq_en` follows bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register word |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Live register word |
| ddr_mode | input | 1 | External DDR mode flag; disables the UHS mode when high |
| resp_busy | input | 1 | Response reception in progress |
| rdata_busy | input | 1 | Read data block reception in progress |
| usr_clk_div | input | DIV_W | User clock divider |
| usr_clk_gen | input | 1 | User clock-generator select |
| preset_bank | input | N_PRESET*(DIV_W+3) | Packed preset entries |
| tune_start | output | 1 | One-cycle tuning start pulse |
| tune_abort | output | 1 | One-cycle tuning abort pulse |
| tune_done | input | 1 | Tuning engine finished |
| tune_pass | input | 1 | Tuning result, valid with tune_done |
| tuner_rst | output | 1 | One-cycle tuning circuit reset |
| eff_drv | output | 2 | Effective driver type |
| eff_clk_div | output | DIV_W | Effective clock divider |
| eff_clk_gen | output | 1 | Effective clock-generator select |
| uhs_active | output | 1 | UHS speed mode in effect |
| eff_uhs_mode | output | 3 | Effective speed mode code |
| volt_1v8 | output | 1 | 1.8 V signaling select |
| vsw_up | output | 1 | One-cycle request to switch to 1.8 V |
| vsw_down | output | 1 | One-cycle request to switch to 3.3 V |
| async_irq_en | output | 1 | Asynchronous interrupt enable |

## Verification
The bench sends directed sequences through the tuning handshake: start then pass, start then fail, abort, completion colliding with an abort write, and stray completions. These separate the priority of completion over writes and show that bit 7 can be set only by a completion. Writes made while the busy inputs are high are compared with the same writes made while idle, which isolates the hold on bit 7. Sweeps of preset enable across all eight speed codes and both signaling levels tell the preset path from the user path and from the 3.3 V override of the driver type. Seeded random mixes of writes, completions, busy and DDR then test every combination against a bench model.

// File: rtl/sdhc_c2_pkg.sv
package sdhc_c2_pkg;
  localparam int UHS_W = 3;
  localparam int DRV_W = 2;
  localparam int N_UHS = 5;

  typedef enum logic [UHS_W-1:0] {
    UHS_SDR12  = 3'd0,
    UHS_SDR25  = 3'd1,
    UHS_SDR50  = 3'd2,
    UHS_SDR104 = 3'd3,
    UHS_DDR50  = 3'd4
  } uhs_mode_e;

  typedef enum logic [DRV_W-1:0] {
    DRV_B = 2'd0,
    DRV_A = 2'd1,
    DRV_C = 2'd2,
    DRV_D = 2'd3
  } drv_e;

  // bit positions the read/write word depends on
  localparam int B_PV   = 15;
  localparam int B_AI   = 14;
  localparam int B_SMP  = 7;
  localparam int B_TUNE = 6;
  localparam int B_DRV  = 4;
  localparam int B_V18  = 3;

  typedef struct packed {
    logic             pv_en;
    logic             aint_en;
    logic             smp_tuned;
    logic             tune_run;
    logic [DRV_W-1:0] drv;
    logic             sig_1v8;
    logic [UHS_W-1:0] uhs;
  } c2_view_t;

  function automatic logic uhs_code_ok(input logic [UHS_W-1:0] c);
    return c <= UHS_DDR50;
  endfunction

  function automatic logic [15:0] c2_pack(input c2_view_t v);
    return {v.pv_en, v.aint_en, 6'b000000, v.smp_tuned, v.tune_run,
            v.drv, v.sig_1v8, v.uhs};
  endfunction
endpackage

// File: rtl/sdhc_c2_tune.sv
module sdhc_c2_tune (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_exec,
  input  logic wr_smp,
  input  logic busy,
  input  logic tune_done,
  input  logic tune_pass,
  output logic tune_run,
  output logic smp_tuned,
  output logic start_pls,
  output logic abort_pls,
  output logic trst_pls
);
  logic run_q, smp_q, start_q, abort_q, trst_q;

  // named internal events
  logic done_acc, sw_start, sw_abort, sw_smp_clr, sw_trst;

  assign done_acc   = tune_done & run_q;
  assign sw_start   = wr_en & wr_exec & ~run_q & ~done_acc;
  assign sw_abort   = wr_en & ~wr_exec & run_q & ~done_acc;
  assign sw_trst    = wr_en & ~wr_smp & ~busy & ~done_acc;
  assign sw_smp_clr = sw_trst | (sw_start & ~busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      smp_q   <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
      trst_q  <= 1'b0;
    end else begin
      start_q <= sw_start;
      abort_q <= sw_abort;
      trst_q  <= sw_trst;
      if (done_acc) begin
        run_q <= 1'b0;
        smp_q <= tune_pass;
      end else begin
        if (sw_start) run_q <= 1'b1;
        else if (sw_abort) run_q <= 1'b0;
        if (sw_smp_clr) smp_q <= 1'b0;
      end
    end
  end

  assign tune_run  = run_q;
  assign smp_tuned = smp_q;
  assign start_pls = start_q;
  assign abort_pls = abort_q;
  assign trst_pls  = trst_q;

  p_start_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (run_q && !$past(run_q)));
  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  p_done_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc |=> (!run_q && smp_q == $past(tune_pass)));
  p_abort_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |=> !abort_q);
  p_no_sw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_q) |-> $past(done_acc));
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_acc) |=> $stable(smp_q));
endmodule

// File: rtl/sdhc_c2_sel.sv
module sdhc_c2_sel
  import sdhc_c2_pkg::*;
#(
  parameter int DIV_W    = 10,
  parameter int N_PRESET = 5,
  localparam int PW      = DIV_W + 3,
  localparam int BANK_W  = N_PRESET * PW
) (
  input  logic             pv_en,
  input  logic [UHS_W-1:0] uhs,
  input  logic             sig_1v8,
  input  logic             ddr_mode,
  input  logic [DRV_W-1:0] usr_drv,
  input  logic [DIV_W-1:0] usr_div,
  input  logic             usr_gen,
  input  logic [BANK_W-1:0] bank,
  output logic [DRV_W-1:0] eff_drv,
  output logic [DIV_W-1:0] eff_div,
  output logic             eff_gen,
  output logic             uhs_active,
  output logic [UHS_W-1:0] eff_uhs,
  output logic             preset_hit
);
  logic [DIV_W-1:0] ent_div [N_PRESET];
  logic             ent_gen [N_PRESET];
  logic [DRV_W-1:0] ent_drv [N_PRESET];

  for (genvar k = 0; k < N_PRESET; k++) begin : g_ent
    assign ent_div[k] = bank[k*PW +: DIV_W];
    assign ent_gen[k] = bank[k*PW + DIV_W];
    assign ent_drv[k] = bank[k*PW + DIV_W + 1 +: DRV_W];
  end

  logic [DIV_W-1:0] p_div;
  logic             p_gen;
  logic [DRV_W-1:0] p_drv;
  logic             p_any;

  always_comb begin
    p_div = '0;
    p_gen = 1'b0;
    p_drv = DRV_B;
    p_any = 1'b0;
    for (int k = 0; k < N_PRESET; k++) begin
      if (int'(uhs) == k) begin
        p_div = ent_div[k];
        p_gen = ent_gen[k];
        p_drv = ent_drv[k];
        p_any = 1'b1;
      end
    end
  end

  assign preset_hit = pv_en & p_any & uhs_code_ok(uhs);
  assign eff_div    = preset_hit ? p_div : usr_div;
  assign eff_gen    = preset_hit ? p_gen : usr_gen;
  assign eff_drv    = !sig_1v8 ? DRV_B : (preset_hit ? p_drv : usr_drv);
  assign uhs_active = sig_1v8 & ~ddr_mode & uhs_code_ok(uhs);
  assign eff_uhs    = uhs_active ? uhs : UHS_SDR12;
endmodule

// File: rtl/sdhc_c2_sig.sv
module sdhc_c2_sig (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_v18,
  output logic v18,
  output logic up_pls,
  output logic dn_pls
);
  logic v18_q, up_q, dn_q, v18_nx;

  assign v18_nx = wr_en ? wr_v18 : v18_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v18_q <= 1'b0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      v18_q <= v18_nx;
      up_q  <= v18_nx & ~v18_q;
      dn_q  <= ~v18_nx & v18_q;
    end
  end

  assign v18    = v18_q;
  assign up_pls = up_q;
  assign dn_pls = dn_q;

  p_up_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (v18_q && !$past(v18_q)));
  p_dn_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dn_q |-> (!v18_q && $past(v18_q)));
endmodule

// File: rtl/sdhc_ctrl2_reg.sv
module sdhc_ctrl2_reg
  import sdhc_c2_pkg::*;
#(
  parameter int DIV_W    = 10,
  parameter int N_PRESET = 5,
  localparam int BANK_W  = N_PRESET * (DIV_W + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  input  logic              ddr_mode,
  input  logic              resp_busy,
  input  logic              rdata_busy,
  input  logic [DIV_W-1:0]  usr_clk_div,
  input  logic              usr_clk_gen,
  input  logic [BANK_W-1:0] preset_bank,
  output logic              tune_start,
  output logic              tune_abort,
  input  logic              tune_done,
  input  logic              tune_pass,
  output logic              tuner_rst,
  output logic [1:0]        eff_drv,
  output logic [DIV_W-1:0]  eff_clk_div,
  output logic              eff_clk_gen,
  output logic              uhs_active,
  output logic [2:0]        eff_uhs_mode,
  output logic              volt_1v8,
  output logic              vsw_up,
  output logic              vsw_down,
  output logic              async_irq_en
);
  logic             pv_q, ai_q;
  logic [DRV_W-1:0] drv_q;
  logic [UHS_W-1:0] uhs_q;
  logic             busy, run, smp, v18, hit;

  assign busy = resp_busy | rdata_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q  <= 1'b0;
      ai_q  <= 1'b0;
      drv_q <= DRV_B;
      uhs_q <= UHS_SDR12;
    end else if (wr_en) begin
      pv_q  <= wr_data[B_PV];
      ai_q  <= wr_data[B_AI];
      drv_q <= wr_data[B_DRV +: DRV_W];
      uhs_q <= wr_data[UHS_W-1:0];
    end
  end

  sdhc_c2_tune u_tune (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_exec   (wr_data[B_TUNE]),
    .wr_smp    (wr_data[B_SMP]),
    .busy      (busy),
    .tune_done (tune_done),
    .tune_pass (tune_pass),
    .tune_run  (run),
    .smp_tuned (smp),
    .start_pls (tune_start),
    .abort_pls (tune_abort),
    .trst_pls  (tuner_rst)
  );

  sdhc_c2_sig u_sig (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_v18 (wr_data[B_V18]),
    .v18    (v18),
    .up_pls (vsw_up),
    .dn_pls (vsw_down)
  );

  sdhc_c2_sel #(.DIV_W(DIV_W), .N_PRESET(N_PRESET)) u_sel (
    .pv_en      (pv_q),
    .uhs        (uhs_q),
    .sig_1v8    (v18),
    .ddr_mode   (ddr_mode),
    .usr_drv    (drv_q),
    .usr_div    (usr_clk_div),
    .usr_gen    (usr_clk_gen),
    .bank       (preset_bank),
    .eff_drv    (eff_drv),
    .eff_div    (eff_clk_div),
    .eff_gen    (eff_clk_gen),
    .uhs_active (uhs_active),
    .eff_uhs    (eff_uhs_mode),
    .preset_hit (hit)
  );

  c2_view_t view;
  always_comb begin
    view.pv_en     = pv_q;
    view.aint_en   = ai_q;
    view.smp_tuned = smp;
    view.tune_run  = run;
    view.drv       = drv_q;
    view.sig_1v8   = v18;
    view.uhs       = uhs_q;
  end

  assign rd_data      = c2_pack(view);
  assign volt_1v8     = v18;
  assign async_irq_en = ai_q;

  p_drv_typeb_3v3_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[B_V18] |-> eff_drv == DRV_B);
  p_uhs_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    uhs_active |-> (rd_data[B_V18] && !ddr_mode && rd_data[2:0] <= 3'd4));
  p_user_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2:0] > 3'd4 || !rd_data[B_PV]) |->
      (eff_clk_div == usr_clk_div && eff_clk_gen == usr_clk_gen));
  p_hit_needs_pv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> rd_data[B_PV]);
endmodule

// File: tb/test_sdhc_ctrl2_reg.sv
`timescale 1ns/1ps
module test_sdhc_ctrl2_reg;
  localparam int DW = 10;
  localparam int NP = 5;
  localparam int PW = DW + 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, wr_en, ddr_mode, resp_busy, rdata_busy, usr_clk_gen;
  logic tune_done, tune_pass;
  logic [15:0] wr_data, rd_data;
  logic [DW-1:0] usr_clk_div, eff_clk_div;
  logic [NP*PW-1:0] preset_bank;
  logic tune_start, tune_abort, tuner_rst, eff_clk_gen, uhs_active;
  logic volt_1v8, vsw_up, vsw_down, async_irq_en;
  logic [1:0] eff_drv;
  logic [2:0] eff_uhs_mode;

  sdhc_ctrl2_reg #(.DIV_W(DW), .N_PRESET(NP)) i_sdhc_ctrl2_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ddr_mode(ddr_mode), .resp_busy(resp_busy),
    .rdata_busy(rdata_busy), .usr_clk_div(usr_clk_div),
    .usr_clk_gen(usr_clk_gen), .preset_bank(preset_bank),
    .tune_start(tune_start), .tune_abort(tune_abort),
    .tune_done(tune_done), .tune_pass(tune_pass), .tuner_rst(tuner_rst),
    .eff_drv(eff_drv), .eff_clk_div(eff_clk_div), .eff_clk_gen(eff_clk_gen),
    .uhs_active(uhs_active), .eff_uhs_mode(eff_uhs_mode),
    .volt_1v8(volt_1v8), .vsw_up(vsw_up), .vsw_down(vsw_down),
    .async_irq_en(async_irq_en)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model
  logic m_pv, m_ai, m_smp, m_run, m_v18;
  logic [1:0] m_drv;
  logic [2:0] m_uhs;
  logic e_start, e_abort, e_trst, e_up, e_dn;
  logic [DW-1:0] pdiv [NP];
  logic pgen [NP];
  logic [1:0] pdrv [NP];

  function automatic logic [NP*PW-1:0] build_bank();
    logic [NP*PW-1:0] b = '0;
    for (int k = 0; k < NP; k++) b[k*PW +: PW] = {pdrv[k], pgen[k], pdiv[k]};
    return b;
  endfunction

  function automatic logic [15:0] model_word();
    return {m_pv, m_ai, 6'd0, m_smp, m_run, m_drv, m_v18, m_uhs};
  endfunction

  function automatic logic model_hit();
    return m_pv && (m_uhs < 3'(NP));
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [1:0] xd;
    logic ua;
    xd = !m_v18 ? 2'd0 : (model_hit() ? pdrv[m_uhs] : m_drv);
    ua = m_v18 && !ddr_mode && m_uhs <= 3'd4;
    chk(32'(rd_data[13:8]), 0, "R2 reserved bits");
    chk(32'(rd_data), 32'(model_word()), "R2 R4 R6 read word");
    chk(32'(rd_data[6]), 32'(m_run), "R3 R4 R5 exec bit");
    chk(32'(rd_data[7]), 32'(m_smp), "R4 R6 R7 sample bit");
    chk(32'(tune_start), 32'(e_start), "R3 start pulse");
    chk(32'(tune_abort), 32'(e_abort), "R5 abort pulse");
    chk(32'(tuner_rst), 32'(e_trst), "R6 R7 tuner reset");
    chk(32'(eff_drv), 32'(xd), "R8 R9 R10 driver");
    chk(32'(eff_clk_div), 32'(model_hit() ? pdiv[m_uhs] : usr_clk_div), "R8 R9 divider");
    chk(32'(eff_clk_gen), 32'(model_hit() ? pgen[m_uhs] : usr_clk_gen), "R8 R9 gen select");
    chk(32'(uhs_active), 32'(ua), "R11 uhs active");
    chk(32'(eff_uhs_mode), 32'(ua ? m_uhs : 3'd0), "R11 uhs mode");
    chk(32'({volt_1v8, vsw_up, vsw_down}), 32'({m_v18, e_up, e_dn}), "R12 voltage");
    chk(32'(async_irq_en), 32'(m_ai), "R13 async enable");
  endtask

  task automatic step(input logic w, input logic [15:0] d, input logic dn,
                      input logic ps, input logic rb, input logic db);
    logic busy, dacc, start;
    @(negedge clk);
    wr_en = w; wr_data = d; tune_done = dn; tune_pass = ps;
    resp_busy = rb; rdata_busy = db;
    @(posedge clk);
    busy = rb | db;
    dacc = dn & m_run;
    start = w & d[6] & ~m_run & ~dacc;
    e_start = start;
    e_abort = w & ~d[6] & m_run & ~dacc;
    e_trst = w & ~d[7] & ~busy & ~dacc;
    e_up = w & d[3] & ~m_v18;
    e_dn = w & ~d[3] & m_v18;
    if (dacc) begin
      m_run = 1'b0; m_smp = ps;
    end else begin
      if (start) m_run = 1'b1;
      else if (e_abort) m_run = 1'b0;
      if (e_trst || (start && !busy)) m_smp = 1'b0;
    end
    if (w) begin
      m_pv = d[15]; m_ai = d[14]; m_drv = d[5:4]; m_v18 = d[3]; m_uhs = d[2:0];
    end
    #1;
    check_all();
  endtask

  initial begin
    void'($urandom(32'h5D0C_2B17));
    rst_n = 1'b0; wr_en = 0; wr_data = 0; tune_done = 0; tune_pass = 0;
    resp_busy = 0; rdata_busy = 0; ddr_mode = 0;
    usr_clk_div = 10'h155; usr_clk_gen = 1'b1;
    for (int k = 0; k < NP; k++) begin
      pdiv[k] = DW'($urandom); pgen[k] = 1'($urandom); pdrv[k] = 2'($urandom);
    end
    preset_bank = build_bank();
    m_pv = 0; m_ai = 0; m_smp = 0; m_run = 0; m_v18 = 0; m_drv = 0; m_uhs = 0;
    e_start = 0; e_abort = 0; e_trst = 0; e_up = 0; e_dn = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(32'(rd_data), 0, "R1 reset word");
    chk(32'({tune_start, tune_abort, tuner_rst, vsw_up, vsw_down}), 0, "R1 reset pulses");
    chk(32'(eff_drv), 0, "R1 reset driver");
    chk(32'(eff_clk_div), 32'(usr_clk_div), "R1 reset divider");
    @(negedge clk); rst_n = 1'b1;

    // directed tuning corners
    step(1, 16'hFFFF, 0, 0, 0, 0);   // R3 start, all writable fields set
    step(1, 16'hFFFF, 0, 0, 0, 0);   // R3 write 1 while running: nothing
    step(0, 16'h0000, 1, 1, 0, 0);   // R4 pass -> bit 7 set
    step(1, 16'h0088, 0, 0, 0, 0);   // R6 write 1 to bit 7 keeps it, no reset
    step(1, 16'h0008, 0, 0, 1, 0);   // R7 busy blocks clear
    step(1, 16'h0008, 0, 0, 0, 1);   // R7 read busy blocks clear
    step(1, 16'h0008, 0, 0, 0, 0);   // R6 clear + tuner reset
    step(0, 16'h0000, 1, 1, 0, 0);   // R4 stray done ignored
    step(1, 16'h00C8, 0, 0, 0, 0);   // R3 start
    step(1, 16'h0088, 0, 0, 0, 0);   // R5 abort
    step(1, 16'h00C8, 0, 0, 0, 0);   // R3 start again
    step(1, 16'h0088, 1, 1, 0, 0);   // R4 done beats abort write
    step(1, 16'h00C8, 0, 0, 1, 0);   // R7 start while busy keeps bit 7
    step(0, 16'h0000, 1, 0, 0, 0);   // R4 fail -> bit 7 clear
    step(1, 16'h0080, 0, 0, 0, 0);   // R12 drop to 3.3 V, R10 driver 0
    // R8 R9 R11 sweep all speed codes, preset on/off, both levels
    for (int pv = 0; pv < 2; pv++)
      for (int v = 0; v < 2; v++)
        for (int c = 0; c < 8; c++)
          step(1, {1'(pv), 1'b0, 6'd0, 1'b1, 1'b0, 2'd2, 1'(v), 3'(c)}, 0, 0, 0, 0);
    ddr_mode = 1'b1;
    step(1, 16'h008B, 0, 0, 0, 0);   // R11 DDR input disables UHS
    ddr_mode = 1'b0;

    // constrained random
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if ($urandom_range(3) != 0) d[7] = 1'b1;
      ddr_mode = ($urandom_range(7) == 0);
      usr_clk_div = DW'($urandom); usr_clk_gen = 1'($urandom);
      if ($urandom_range(15) == 0) begin
        for (int k = 0; k < NP; k++) begin
          pdiv[k] = DW'($urandom); pgen[k] = 1'($urandom); pdrv[k] = 2'($urandom);
        end
        preset_bank = build_bank();
      end
      step(($urandom_range(9) < 6), d, ($urandom_range(6) == 0), 1'($urandom),
           ($urandom_range(9) == 0), ($urandom_range(9) == 0));
    end
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule